// File: doc/BRIEF.md
# Address-Masked GPIO Port Register

This block is a general-purpose I/O port of eight pins seen by software as a small set of byte-wide registers. One register sets the direction of each pin. A second register holds the value driven on the pins that are outputs. Each pad is modelled as three separate vectors: the value driven out, an output enable and the value coming in. Every incoming pad value passes through a two-stage synchroniser before any logic reads it.

Pin data is reached through a 256-word window rather than through a single address. Within that window, the word address itself works as a per-pin bit mask. A write changes only the pins whose mask bit is set. A read returns zero on the bits that are not selected. Software can therefore set or clear one pin with a single store, with no read-modify-write sequence and no lock. A write has no effect on a pin that is configured as an input, so driver code writes the value again after it turns a pin into an output.

The block also returns a fixed set of identification bytes. Reads have a latency of one cycle. `rdata` takes its new value at the clock edge that samples `rd_en` high, and it holds that value until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pad_oe`, `pad_out` and `rdata` are all 0. After reset every pin is an input and a direction read returns 0.
- R2: A write to offset 0x400 loads `wdata` into the direction register, and the new value appears on `pad_oe` one cycle later. Bit n set to 1 makes pin n an output, and set to 0 makes it an input. A read at offset 0x400 returns that register with pin n in bit n.
- R3: A write to a word-aligned offset in 0x000–0x3FC updates output bit n from `wdata[n]` only when address bit n+2 is 1 and pin n is an output. Every other output bit keeps its value. `pad_out` shows the result one cycle after the write.
- R4: A data write leaves the stored output bit of an input pin unchanged. After that pin is switched to output, it drives the value it held before that write.
- R5: A read in the data window returns 0 on every bit n whose address bit n+2 is 0.
- R6: On a selected bit, a data read returns the driven output value when pin n is an output, and the synchronised pad value when pin n is an input.
- R7: Each pad input goes through two flops. A pad change first sampled at clock edge E1 is not returned by a read sampled at edge E1+1. It is returned by a read sampled at edge E1+2.
- R8: A read at offset 0xFE0 + 4k, for k from 0 to 3, returns byte k of the identification word 0x00041061, with byte 0 being the least significant. Writes to those offsets change nothing.
- R9: A read of any other offset returns 0, and a write to any other offset changes neither `pad_out` nor `pad_oe`. Examples are 0x404, 0x800, and any offset whose bits [1:0] are not 00.
- R10: `rdata` changes only at a clock edge that samples `rd_en` high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per transfer |
| rd_en | input | 1 | Read strobe, one cycle per transfer |
| addr | input | ADDR_W (12) | Byte offset of the transfer |
| wdata | input | NPINS (8) | Write data |
| rdata | output | NPINS (8) | Registered read data, valid the cycle after `rd_en` |
| pad_in | input | NPINS (8) | Asynchronous pad input values |
| pad_out | output | NPINS (8) | Registered pad drive values |
| pad_oe | output | NPINS (8) | Registered pad output enables, equal to the direction register |

## Verification
The direction and output registers drive `pad_oe` and `pad_out` directly. A wrong bit in either register therefore shows at the pads in the cycle after the write that caused it, and stays there until it is rewritten. A mask or gating fault has two visible effects: a pin outside the address mask changes, or an input pin keeps a value that shows up later when the pin is switched to output. Faults in the read path and the synchroniser show in `rdata` one cycle after the read. A stage that is missing from the synchroniser shows as a fresh pad value that can be read one edge early.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Decoded target of the current transfer
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_ID   = 2'd3
  } sel_e;

  // Width of one identification byte
  localparam int ID_BYTE_W = 8;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int          NPINS    = 8,
  parameter int          ADDR_W   = 12,
  parameter int unsigned DIR_OFF  = 'h400,
  parameter int unsigned ID_BASE  = 'hFE0,
  parameter int          ID_BYTES = 4,
  parameter int          IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  id_idx,
  output logic [NPINS-1:0]  pin_mask
);

  localparam int          WIN_LSB = NPINS + 2;
  localparam int unsigned ID_END  = ID_BASE + 32'(4 * ID_BYTES);

  logic [31:0] a32;
  logic        aligned;

  assign a32      = 32'(addr);
  assign aligned  = (addr[1:0] == 2'b00);
  assign pin_mask = addr[WIN_LSB-1:2];

  always_comb begin
    sel    = SEL_NONE;
    id_idx = '0;
    if (aligned) begin
      if ((a32 >> WIN_LSB) == 32'd0) begin
        sel = SEL_DATA;
      end else if (a32 == DIR_OFF) begin
        sel = SEL_DIR;
      end else if ((a32 >= ID_BASE) && (a32 < ID_END)) begin
        sel    = SEL_ID;
        id_idx = IDX_W'((a32 - ID_BASE) >> 2);
      end
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic             data_we,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pin_mask,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (dir_we) begin
      dir_q <= wdata;
    end
  end

  // Each output bit accepts a write only when it is selected and is an output
  for (genvar i = 0; i < NPINS; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[i] <= 1'b0;
      end else if (data_we && pin_mask[i] && dir_q[i]) begin
        out_q[i] <= wdata[i];
      end
    end
  end

endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
  import gpio_mask_pkg::*;
#(
  parameter int                          NPINS    = 8,
  parameter int                          ID_BYTES = 4,
  parameter int                          IDX_W    = 2,
  parameter logic [ID_BYTE_W*ID_BYTES-1:0] ID_WORD  = 32'h0004_1061
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  sel_e             sel,
  input  logic [IDX_W-1:0] id_idx,
  input  logic [NPINS-1:0] pin_mask,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] sync_in,
  output logic [NPINS-1:0] rdata
);

  logic [ID_BYTE_W-1:0] id_tab [ID_BYTES];
  logic [NPINS-1:0]     pin_view;
  logic [NPINS-1:0]     rd_nxt;

  for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
    assign id_tab[k] = ID_WORD[ID_BYTE_W*k +: ID_BYTE_W];
  end

  // Outputs read back what they drive, inputs read the synchronised pad
  assign pin_view = (dir_q & out_q) | (~dir_q & sync_in);

  always_comb begin
    case (sel)
      SEL_DATA: rd_nxt = pin_mask & pin_view;
      SEL_DIR:  rd_nxt = dir_q;
      SEL_ID:   rd_nxt = NPINS'(id_tab[id_idx]);
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_nxt;
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int                          NPINS    = 8,
  parameter int                          ADDR_W   = 12,
  parameter int unsigned                 DIR_OFF  = 'h400,
  parameter int unsigned                 ID_BASE  = 'hFE0,
  parameter int                          ID_BYTES = 4,
  parameter logic [ID_BYTE_W*ID_BYTES-1:0] ID_WORD  = 32'h0004_1061
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  sel_e             sel;
  logic [IDX_W-1:0] id_idx;
  logic [NPINS-1:0] pin_mask;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] sync_in;
  logic             dir_we;
  logic             data_we;

  gpio_addr_decode #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF),
    .ID_BASE(ID_BASE), .ID_BYTES(ID_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .sel(sel), .id_idx(id_idx), .pin_mask(pin_mask)
  );

  assign dir_we  = wr_en && (sel == SEL_DIR);
  assign data_we = wr_en && (sel == SEL_DATA);

  gpio_port_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .dir_we(dir_we), .data_we(data_we),
    .wdata(wdata), .pin_mask(pin_mask), .dir_q(dir_q), .out_q(out_q)
  );

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_in)
  );

  gpio_read_path #(
    .NPINS(NPINS), .ID_BYTES(ID_BYTES), .IDX_W(IDX_W), .ID_WORD(ID_WORD)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .id_idx(id_idx),
    .pin_mask(pin_mask), .dir_q(dir_q), .out_q(out_q), .sync_in(sync_in),
    .rdata(rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int          NPINS   = 8,
  parameter int          ADDR_W  = 12,
  parameter int unsigned DIR_OFF = 'h400
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wdata,
  input logic [NPINS-1:0]  rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);

  logic             rst_q;
  logic             in_win;
  logic             dir_hit;
  logic [NPINS-1:0] msk;

  always_ff @(posedge clk) rst_q <= rst;

  assign in_win  = ((32'(addr) >> (NPINS + 2)) == 32'd0) && (addr[1:0] == 2'b00);
  assign dir_hit = (32'(addr) == DIR_OFF);
  assign msk     = addr[NPINS+1:2];

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_clear_chk: assert (pad_oe == '0 && pad_out == '0 && rdata == '0);
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dir_hit) |=> (pad_oe == $past(wdata)));

  // R3
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_win) |=>
      (pad_out == (($past(pad_out) & ~($past(msk) & $past(pad_oe))) |
                   ($past(wdata) & $past(msk) & $past(pad_oe)))));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && in_win) |=> $stable(pad_out));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && dir_hit) |=> $stable(pad_oe));

  // R5
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_win) |=> ((rdata & ~$past(msk)) == '0));

  // R9
  misaligned_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[1:0] != 2'b00)) |=> (rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)
) u_chk (.*);

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;

  localparam logic [31:0] TB_ID = 32'h0004_1061;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];

  logic [7:0] m_dir = '0;
  logic [7:0] m_out = '0;
  logic [7:0] m_pin = '0;

  always #4 clk = ~clk;

  gpio_mask_port dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 8'h00;
    if (a[11:10] == 2'b00) return a[9:2] & ((m_dir & m_out) | (~m_dir & m_pin));
    if (a == 12'h400) return m_dir;
    if (a >= 12'hFE0 && a < 12'hFF0) return TB_ID[8*a[3:2] +: 8];
    return 8'h00;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    if (a[1:0] == 2'b00 && a[11:10] == 2'b00)
      m_out = (m_out & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
    else if (a == 12'h400)
      m_dir = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issue a read and queue its expected value
  task automatic do_read(input logic [11:0] a, input logic [7:0] exp, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    it.val = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd_model(input logic [11:0] a, input string tag);
    do_read(a, model_rd(a), tag);
  endtask

  // Monitor: compare each read result the cycle it appears
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard R10 actual=%02h expected=none", rdata);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check8(it.tag, rdata, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 pad_oe in reset", pad_oe, 8'h00);
    check8("R1 rdata in reset", rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check8("R1 pad_oe after reset", pad_oe, 8'h00);
    check8("R1 pad_out after reset", pad_out, 8'h00);
    rd_model(12'h400, "R1 direction read");
    rd_model(12'h3FC, "R1 data read");

    do_write(12'h400, 8'hF0);
    check8("R2 pad_oe", pad_oe, 8'hF0);
    rd_model(12'h400, "R2 direction read");

    do_write(12'h3FC, 8'hFF);
    check8("R3 full-mask write", pad_out, 8'hF0);
    do_write(12'h040, 8'h00);
    check8("R3 single pin clear", pad_out, 8'hE0);
    do_write(12'h300, 8'h00);
    check8("R3 two pin clear", pad_out, 8'h20);
    check8("R3 model", pad_out, m_out);

    do_write(12'h00C, 8'h03);
    check8("R4 write to inputs", pad_out, 8'h20);
    do_write(12'h400, 8'hFF);
    check8("R4 after switch", pad_out, 8'h20);
    do_write(12'h00C, 8'h03);
    check8("R4 rewrite", pad_out, 8'h23);

    do_write(12'h400, 8'h0F);
    @(negedge clk);
    pad_in = 8'hA5;
    idle(4);
    m_pin = 8'hA5;
    rd_model(12'h3FC, "R6 full read");
    rd_model(12'h0C0, "R5 input pair");
    rd_model(12'h030, "R5 output pair");
    do_read(12'h008, 8'h02, "R6 output not pad");
    do_read(12'h004, 8'h01, "R5 single pin");

    @(negedge clk);
    rd_en = 1'b0;
    pad_in = 8'h25;
    do_read(12'h200, 8'h80, "R7 second edge old");
    do_read(12'h200, 8'h00, "R7 third edge new");
    m_pin = 8'h25;

    for (int k = 0; k < 4; k++) begin
      do_read(12'hFE0 + 12'(4 * k), TB_ID[8*k +: 8], "R8 id byte");
    end
    do_write(12'hFE0, 8'hFF);
    rd_model(12'hFE0, "R8 id after write");
    check8("R8 pads after id write", pad_out, m_out);

    rd_model(12'h404, "R9 read 0x404");
    rd_model(12'h005, "R9 misaligned read");
    rd_model(12'h800, "R9 read 0x800");
    do_write(12'h404, 8'h00);
    do_write(12'h401, 8'h00);
    check8("R9 dir unchanged", pad_oe, 8'h0F);
    do_write(12'h801, 8'h00);
    do_write(12'h3FD, 8'h00);
    check8("R9 out unchanged", pad_out, 8'h23);

    rd_model(12'h400, "R10 last read");
    idle(4);
    check8("R10 rdata held", rdata, 8'h0F);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule